// File: doc/BRIEF.md
# Polled SPI Master with Transmit and Receive FIFOs

This block is a synchronous serial master that sits behind a simple 16-bit register bus. Software sets the frame width, the clock polarity, the clock phase and the bit rate in control registers. It then writes frames into an eight-entry transmit queue through a data register. The block sends each frame most significant bit first on `mosi` while it samples `miso`, so every frame it sends yields one received frame. That frame lands, right-justified, in an eight-entry receive queue. Software reads it back from the same data address.

The serial clock comes from two divide stages. The first is an even prescaler from 2 to 254. The second multiplies that by one plus an 8-bit rate value, so one bit lasts prescale × (1 + rate) system clocks. A status register exposes the queue flags and a busy flag, which lets a polling driver keep the transmit side fed and drain the receive side. Read-only identification registers let a driver recognise the block.

Bus reads are combinational on `bus_addr`. Writes, and the pop caused by a data read, take effect on the rising clock edge. Software changes the frame configuration only while the block is not busy.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, the following hold. Status (0x00C) reads 0x0003. Prescale (0x010) reads 2. Control 0 (0x000) and control 1 (0x004) read 0. `sclk` is low.
- R2: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC read 0x22, 0x10, 0x04 and 0x00. Unmapped offsets read 0.
- R3: A write to prescale stores the value with bit 0 cleared. A value that becomes 0 this way is stored as 2. Only bits 7:0 are kept.
- R4: The transmit queue holds 8 frames. Status bit 0 means transmit empty and bit 1 means transmit not full. A data write (0x008) while the queue is full is dropped.
- R5: Each frame sent pushes one received frame, right-justified with zero upper bits. Status bit 2 means receive not empty and bit 3 means receive full. A received frame that arrives while the receive queue is full is discarded. A data read with an empty receive queue returns 0.
- R6: Status bit 4 (busy) is 1 while a frame is shifting. It is also 1 while the port is enabled and the transmit queue is not empty. Otherwise it is 0.
- R7: Successive `sclk` edges within a frame are (prescale/2) × (1 + SCR) clocks apart, where SCR is control 0 bits 15:8. A frame of n bits has exactly 2n edges.
- R8: Control 0 bits 3:0 hold frame size minus one. The frame is sent most significant bit first from bit n-1 of the written word, and the n sampled `miso` bits form the received word.
- R9: Control 0 bit 6 is polarity and bit 7 is phase. `sclk` idles at the polarity level. With phase 0, data is sampled on the first edge of each bit. With phase 1, data is sampled on the second edge.
- R10: Control 1 bit 1 enables the port. While it is 0, no frame starts, `sclk` stays at idle and queued frames are kept. Clearing it mid-frame abandons that frame: `sclk` returns to idle and nothing is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops receive queue at 0x008) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default queue depth of 8. It sweeps three prescale values (2, 4, 6), three rate values (0 to 2), all four polarity and phase modes, and frame sizes of 4, 8 and 16 bits. Because these dividers are small, every combination completes within a few hundred clocks. A passive monitor on `sclk` checks edge spacing, edge count and the sampled `mosi` bits, while an inverting loopback on `miso` checks the received word. Separate passes fill both queues to their limits, exercise the prescale write rules and abort a slow frame by clearing the enable.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_DAT  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] A_STA  = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] A_PSC  = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] A_ID0  = ADDR_W'(12'hFE0);
  localparam logic [ADDR_W-1:0] A_ID1  = ADDR_W'(12'hFE4);
  localparam logic [ADDR_W-1:0] A_ID2  = ADDR_W'(12'hFE8);
  localparam logic [ADDR_W-1:0] A_ID3  = ADDR_W'(12'hFEC);

  logic [3:0]  fsz;
  logic        cpol, cpha, en;
  logic [7:0]  scr, psc;

  logic [15:0] txm [DEPTH];
  logic [15:0] rxm [DEPTH];
  logic [AW:0] twp, trp, rwp, rrp;
  logic [AW:0] tx_cnt, rx_cnt;
  logic        tx_empty, tx_full, rx_empty, rx_full;

  logic        active, tog;
  logic [4:0]  e, em1, last_e;
  logic [15:0] cnt, half, txf, rxs, rx_next, rx_word;
  logic [3:0]  idx, bitpos;
  logic        tick, sample, start, done, busy;
  logic        tx_push, rx_pop, rx_push;

  assign tx_cnt   = twp - trp;
  assign rx_cnt   = rwp - rrp;
  assign tx_empty = (twp == trp);
  assign rx_empty = (rwp == rrp);
  assign tx_full  = (tx_cnt == (AW+1)'(DEPTH));
  assign rx_full  = (rx_cnt == (AW+1)'(DEPTH));

  assign half    = 16'(psc[7:1]) * (16'(scr) + 16'd1);
  assign tick    = active && (cnt == half - 16'd1);
  assign last_e  = {fsz, 1'b1};
  assign sample  = tick && (e[0] == cpha);
  assign done    = tick && (e == last_e);
  assign start   = en && !active && !tx_empty;
  assign em1     = e - 5'd1;
  assign idx     = cpha ? ((e == 5'd0) ? 4'd0 : em1[4:1]) : e[4:1];
  assign bitpos  = fsz - idx;
  assign mosi    = active && txf[bitpos];
  assign sclk    = cpol ^ tog;
  assign rx_next = {rxs[14:0], miso};
  assign rx_word = sample ? rx_next : rxs;
  assign busy    = active || (en && !tx_empty);

  assign tx_push = bus_wr && (bus_addr == A_DAT) && !tx_full;
  assign rx_pop  = bus_rd && (bus_addr == A_DAT) && !rx_empty;
  assign rx_push = done && !rx_full;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[5:4], bus_wdata[15:2], em1[0], bus_wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsz <= '0; cpol <= 1'b0; cpha <= 1'b0; scr <= '0;
      en  <= 1'b0; psc <= 8'd2;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CFG: begin
          fsz  <= bus_wdata[3:0];
          cpol <= bus_wdata[6];
          cpha <= bus_wdata[7];
          scr  <= bus_wdata[15:8];
        end
        A_ENA: en <= bus_wdata[1];
        A_PSC: psc <= (bus_wdata[7:1] == 7'd0) ? 8'd2 : {bus_wdata[7:1], 1'b0};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; rwp <= '0; rrp <= '0;
    end else begin
      if (tx_push) twp <= twp + 1'b1;
      if (start)   trp <= trp + 1'b1;
      if (rx_push) rwp <= rwp + 1'b1;
      if (rx_pop)  rrp <= rrp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[twp[AW-1:0]] <= bus_wdata;
    if (rx_push) rxm[rwp[AW-1:0]] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; tog <= 1'b0; e <= '0; cnt <= '0;
      txf <= '0; rxs <= '0;
    end else if (!en) begin
      active <= 1'b0;
      tog    <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      txf    <= txm[trp[AW-1:0]];
      e      <= '0;
      cnt    <= '0;
      tog    <= 1'b0;
      rxs    <= '0;
    end else if (active) begin
      if (tick) begin
        cnt <= '0;
        e   <= e + 5'd1;
        tog <= ~tog;
        if (sample) rxs <= rx_next;
        if (e == last_e) active <= 1'b0;
      end else begin
        cnt <= cnt + 16'd1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = {scr, cpha, cpol, 2'b00, fsz};
      A_ENA:   bus_rdata = {14'd0, en, 1'b0};
      A_DAT:   bus_rdata = rx_empty ? 16'd0 : rxm[rrp[AW-1:0]];
      A_STA:   bus_rdata = {11'd0, busy, rx_full, !rx_empty, !tx_full, tx_empty};
      A_PSC:   bus_rdata = {8'd0, psc};
      A_ID0:   bus_rdata = 16'h0022;
      A_ID1:   bus_rdata = 16'h0010;
      A_ID2:   bus_rdata = 16'h0004;
      A_ID3:   bus_rdata = 16'h0000;
      default: bus_rdata = 16'd0;
    endcase
  end

  a_r4_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= (AW+1)'(DEPTH));
  a_r5_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= (AW+1)'(DEPTH));
  a_r6_start_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(en && !tx_empty));
  a_r10_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !active);
  a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (sclk == cpol));
  a_r5_push_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(active) && $past(en) && !$past(rx_full)) |-> (rx_cnt == $past(rx_cnt) + (AW+1)'(1) - (AW+1)'($past(rx_pop))));
endmodule

// File: tb/spi_fifo_master_test.sv
module spi_fifo_master_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        sclk, mosi, miso;

  int total = 0, fails = 0;
  int cyc = 0, edges = 0, bad_gap = 0, last_cyc = -1, exp_half = 1;
  logic [15:0] mon_bits = '0;
  logic sprev = 1'b0, mprev = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0;

  assign miso = ~mosi;

  spi_fifo_master uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && sclk != sprev) begin
      edges = edges + 1;
      if ((sprev == m_cpol) != m_cpha) mon_bits = {mon_bits[14:0], mprev};
      if (last_cyc >= 0 && (cyc - last_cyc) != exp_half) bad_gap = bad_gap + 1;
      last_cyc = cyc;
    end
    sprev = sclk;
    mprev = mosi;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1; d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic clear_mon();
    @(negedge clk); #1;
    edges = 0; bad_gap = 0; last_cyc = -1; mon_bits = '0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    s = 16'h10;
    for (int k = 0; k < 5000 && s[4]; k++) rd(12'h00C, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] words [9];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 sclk idle", 32'(sclk), 0);
    rd(12'h00C, v); chk("R1 status", 32'(v), 32'h3);
    rd(12'h010, v); chk("R1 prescale", 32'(v), 2);
    rd(12'h000, v); chk("R1 ctrl0", 32'(v), 0);
    rd(12'h004, v); chk("R1 ctrl1", 32'(v), 0);

    rd(12'hFE0, v); chk("R2 id0", 32'(v), 32'h22);
    rd(12'hFE4, v); chk("R2 id1", 32'(v), 32'h10);
    rd(12'hFE8, v); chk("R2 id2 low nibble", 32'(v[3:0]), 4);
    rd(12'hFEC, v); chk("R2 id3", 32'(v), 0);
    rd(12'h040, v); chk("R2 unmapped", 32'(v), 0);

    wr(12'h010, 16'd5);    rd(12'h010, v); chk("R3 odd", 32'(v), 4);
    wr(12'h010, 16'd0);    rd(12'h010, v); chk("R3 zero", 32'(v), 2);
    wr(12'h010, 16'd1);    rd(12'h010, v); chk("R3 one", 32'(v), 2);
    wr(12'h010, 16'h01FF); rd(12'h010, v); chk("R3 max", 32'(v), 254);

    wr(12'h004, 16'h0002);
    for (int p = 2; p <= 6; p += 2)
      for (int r = 0; r < 3; r++)
        for (int m = 0; m < 4; m++)
          for (int z = 0; z < 3; z++) begin
            int n;
            logic [15:0] tx, mask;
            n = (z == 0) ? 4 : (z == 1) ? 8 : 16;
            mask = 16'((32'h1 << n) - 1);
            tx = 16'hA53C ^ 16'(p * 16'h1357 + r * 16'h0F0F + m * 16'h3333 + n * 16'h0101);
            wr(12'h010, 16'(p));
            wr(12'h000, {8'(r), m[1], m[0], 2'b00, 4'(n - 1)});
            m_cpol = m[0]; m_cpha = m[1]; exp_half = (p / 2) * (r + 1);
            clear_mon();
            wr(12'h008, tx);
            wait_idle();
            rd(12'h008, v);
            chk("R5 R8 loopback word", 32'(v), 32'(~tx & mask));
            chk("R8 R9 sampled mosi", 32'(mon_bits & mask), 32'(tx & mask));
            chk("R7 edge count", edges, 2 * n);
            chk("R7 edge spacing", bad_gap, 0);
            chk("R9 idle level", 32'(sclk), 32'(m[0]));
          end

    wr(12'h004, 16'h0000);
    wr(12'h010, 16'd2);
    wr(12'h000, 16'h0007);
    m_cpol = 1'b0; m_cpha = 1'b0; exp_half = 1;
    clear_mon();
    for (int i = 0; i < 9; i++) begin
      words[i] = 16'(8'h3C + i * 8'h29);
      wr(12'h008, words[i]);
    end
    rd(12'h00C, v); chk("R4 R6 R10 full while disabled", 32'(v), 32'h0);
    chk("R10 no edges while disabled", edges, 0);
    wr(12'h004, 16'h0002);
    rd(12'h00C, v); chk("R6 busy after enable", 32'(v[4]), 1);
    wait_idle();
    rd(12'h00C, v); chk("R5 rx full status", 32'(v), 32'h0F);
    chk("R4 eight frames only", edges, 8 * 16);
    wr(12'h008, 16'h00AA);
    wait_idle();
    rd(12'h00C, v); chk("R5 discard keeps full", 32'(v), 32'h0F);
    for (int i = 0; i < 8; i++) begin
      rd(12'h008, v);
      chk("R5 R4 queued order", 32'(v), 32'(~words[i] & 16'h00FF));
    end
    rd(12'h008, v); chk("R5 empty read", 32'(v), 0);
    rd(12'h00C, v); chk("R5 R6 drained status", 32'(v), 32'h3);

    wr(12'h004, 16'h0000);
    wr(12'h010, 16'd254);
    wr(12'h000, 16'h004F);
    m_cpol = 1'b1;
    wr(12'h004, 16'h0002);
    wr(12'h008, 16'h1234);
    repeat (300) @(negedge clk);
    wr(12'h004, 16'h0000);
    repeat (2) @(negedge clk);
    chk("R10 abort idle level", 32'(sclk), 1);
    rd(12'h00C, v); chk("R10 abort status", 32'(v), 32'h3);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule